// File: doc/BRIEF.md
# Fail-safe clock source selector

This block picks the source and the power-of-two divider for three system clocks: an auxiliary clock, a main clock and a sub-main clock. Four candidate sources feed it: an external crystal, a 32768 Hz internal reference, a very-low-power clock of roughly 10 kHz and a divided oscillator clock. Every clock is carried as a single-cycle strobe of a fast sampling clock. A strobe marks one rising edge of that source, and each output strobe marks one edge of the gated, divided clock.

A watchdog counts reference edges. When 64 of them pass with no crystal edge, the crystal counts as failed for as long as that lasts. During that time, any destination that selects the crystal runs from a safe source instead. The auxiliary clock always falls back to the reference. The main and sub-main clocks fall back to the reference when the crystal is in low-frequency mode and to the oscillator clock when it is in high-frequency mode. Every change of the source a destination actually uses passes through a one-cycle quiet gap. Sticky fault flags for the crystal and the oscillator, and a global flag above them, record what happened until software clears them.

Top module: `clksel_failsafe`

## Requirements
- R1: The auxiliary select field picks its source with this encoding: 0 is the crystal, 1 is the reference, and 2 or 3 is the very-low-power clock. The auxiliary output passes every edge of its source undivided.
- R2: The main and sub-main clocks share one source select field with this encoding: 0 is the crystal, 1 is the reference, 2 is the very-low-power clock and 3 is the oscillator clock.
- R3: The main divider field is 3 bits wide and the sub-main divider field is 2 bits wide. A field value n gives one output edge for every 2^n source edges, and that output edge falls on the last source edge of each group.
- R4: While the crystal is enabled, the crystal fault condition holds once 64 reference edges have arrived with no crystal edge. The condition ends in the cycle after a crystal edge arrives.
- R5: While the crystal fault holds, an auxiliary clock that selects the crystal runs from the reference instead, whatever the crystal mode.
- R6: While the crystal fault holds, a main or sub-main clock that selects the crystal runs from the reference when the crystal mode bit is 0 (low frequency) and from the oscillator clock when that bit is 1 (high frequency).
- R7: The crystal fault flag sets in the cycle after the fault condition. It stays set until a clear strobe arrives. If the fault condition is still present when the clear strobe arrives, the flag stays set.
- R8: The oscillator fault flag sets in the cycle after the raw oscillator fault input is high. It stays set until its own clear strobe arrives, and setting wins over clearing.
- R9: The global fault flag sets in the cycle after either per-oscillator flag is set. Its own clear strobe clears it only when neither per-oscillator flag is set.
- R10: While the sub-main off bit is high, the sub-main output gives no edges and its divider count is held.
- R11: With the auto-off bit high and neither select field choosing the crystal, the crystal is disabled. Its watchdog then stays at zero and no crystal fault can arise.
- R12: When the source a destination should use differs from the source it is using, the destination's output is quiet for exactly one gap cycle. The new source takes over after that cycle, and its divider count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xt_tick_i | input | 1 | Crystal edge strobe |
| ref_tick_i | input | 1 | 32768 Hz reference edge strobe |
| vlo_tick_i | input | 1 | Very-low-power clock edge strobe |
| osc_tick_i | input | 1 | Divided oscillator edge strobe |
| osc_fault_i | input | 1 | Raw oscillator fault detector |
| xt_hf_i | input | 1 | Crystal mode: 0 low, 1 high frequency |
| xt_autooff_i | input | 1 | Disable the crystal when nothing selects it |
| aux_sel_i | input | 2 | Auxiliary source select |
| ms_sel_i | input | 2 | Shared main/sub-main source select |
| main_div_i | input | 3 | Main divider exponent |
| sub_div_i | input | 2 | Sub-main divider exponent |
| sub_off_i | input | 1 | Gate the sub-main clock off |
| clr_xt_flag_i | input | 1 | Clear strobe for the crystal fault flag |
| clr_osc_flag_i | input | 1 | Clear strobe for the oscillator fault flag |
| clr_glob_flag_i | input | 1 | Clear strobe for the global fault flag |
| aux_tick_o | output | 1 | Auxiliary clock edge strobe |
| main_tick_o | output | 1 | Main clock edge strobe |
| sub_tick_o | output | 1 | Sub-main clock edge strobe |
| xt_fault_flag_o | output | 1 | Sticky crystal fault flag |
| osc_fault_flag_o | output | 1 | Sticky oscillator fault flag |
| glob_fault_flag_o | output | 1 | Sticky global fault flag |

## Verification
Two things can fall in the same cycle. A software clear can arrive while the fault that set the flag is still present, and a select change can arrive while a fallback switch is still in its gap cycle. The bench provokes the first by pulsing the crystal and global clear strobes while the crystal edges are stopped. It provokes the second by stepping the shared select on consecutive cycles. In both cases a behavioural model, which applies set-over-clear and takes the latest wanted source, is compared with every output on every clock.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int MAIN_DIV_W = 3;
  localparam int SUB_DIV_W  = 2;
  localparam int DIV_W_MAX  = (MAIN_DIV_W > SUB_DIV_W) ? MAIN_DIV_W : SUB_DIV_W;
  localparam int CNT_W      = (1 << DIV_W_MAX) - 1;
  localparam int N_DEST     = 3;

  typedef enum logic [1:0] {
    SRC_XT  = 2'd0,
    SRC_REF = 2'd1,
    SRC_VLO = 2'd2,
    SRC_OSC = 2'd3
  } src_e;

  // Source the auxiliary clock should run from
  function automatic src_e aux_pick(input logic [1:0] sel, input logic fault);
    case (sel)
      2'd0:    return fault ? SRC_REF : SRC_XT;
      2'd1:    return SRC_REF;
      default: return SRC_VLO;
    endcase
  endfunction

  // Source the main and sub-main clocks should run from
  function automatic src_e ms_pick(input logic [1:0] sel, input logic fault, input logic hf);
    if (sel == 2'd0 && fault) return hf ? SRC_OSC : SRC_REF;
    return src_e'(sel);
  endfunction

  // Terminal count of a 2^d divider
  function automatic logic [CNT_W-1:0] div_last(input logic [DIV_W_MAX-1:0] d);
    return (CNT_W'(1) << d) - CNT_W'(1);
  endfunction
endpackage

// File: rtl/clksel_watchdog.sv
module clksel_watchdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic xt_tick_i,
  input  logic ref_tick_i,
  output logic fault_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (!en_i || xt_tick_i)             cnt_q <= '0;
    else if (ref_tick_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + CW'(1);
  end

  assign fault_o = en_i && (cnt_q == CW'(LIMIT));

  AST_WD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xt_tick_i |=> !fault_o); // R4
  AST_WD_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick_i && !fault_o) |=> !fault_o); // R4
  AST_WD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
  import clksel_pkg::*;
#(
  parameter src_e RST_SRC = SRC_REF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  src_e                 want_i,
  input  logic [3:0]           ticks_i,
  input  logic [DIV_W_MAX-1:0] div_i,
  input  logic                 run_i,
  output logic                 tick_o
);
  src_e             cur_q;
  logic             gap_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             src_tick;
  logic             terminal;

  assign last     = div_last(div_i);
  assign src_tick = ticks_i[cur_q];
  assign terminal = (cnt_q >= last);
  assign tick_o   = run_i && !gap_q && src_tick && terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RST_SRC;
      gap_q <= 1'b0;
      cnt_q <= '0;
    end else if (gap_q) begin
      cur_q <= want_i;
      gap_q <= 1'b0;
      cnt_q <= '0;
    end else if (want_i != cur_q) begin
      gap_q <= 1'b1;
    end else if (run_i && src_tick) begin
      cnt_q <= terminal ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q |=> !gap_q); // R12
  AST_SRC_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> $past(gap_q)); // R12
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q |=> (cnt_q == '0)); // R12
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !gap_q && want_i == cur_q) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/clksel_failsafe.sv
module clksel_failsafe
  import clksel_pkg::*;
#(
  parameter int WD_LIMIT = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xt_tick_i,
  input  logic                  ref_tick_i,
  input  logic                  vlo_tick_i,
  input  logic                  osc_tick_i,
  input  logic                  osc_fault_i,
  input  logic                  xt_hf_i,
  input  logic                  xt_autooff_i,
  input  logic [1:0]            aux_sel_i,
  input  logic [1:0]            ms_sel_i,
  input  logic [MAIN_DIV_W-1:0] main_div_i,
  input  logic [SUB_DIV_W-1:0]  sub_div_i,
  input  logic                  sub_off_i,
  input  logic                  clr_xt_flag_i,
  input  logic                  clr_osc_flag_i,
  input  logic                  clr_glob_flag_i,
  output logic                  aux_tick_o,
  output logic                  main_tick_o,
  output logic                  sub_tick_o,
  output logic                  xt_fault_flag_o,
  output logic                  osc_fault_flag_o,
  output logic                  glob_fault_flag_o
);
  logic                 xt_on;
  logic                 xt_fault;
  logic [3:0]           ticks;
  src_e                 want   [N_DEST];
  logic [DIV_W_MAX-1:0] div_sel[N_DEST];
  logic                 run    [N_DEST];
  logic                 dtick  [N_DEST];
  logic                 xt_flag_q, osc_flag_q, glob_q;

  // Crystal stays powered unless auto-off is set and nobody selects it
  assign xt_on = !xt_autooff_i || (aux_sel_i == 2'd0) || (ms_sel_i == 2'd0);
  assign ticks = {osc_tick_i, vlo_tick_i, ref_tick_i, xt_tick_i};

  clksel_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (xt_on),
    .xt_tick_i (xt_tick_i),
    .ref_tick_i(ref_tick_i),
    .fault_o   (xt_fault)
  );

  always_comb begin
    want[0]    = aux_pick(aux_sel_i, xt_fault);
    want[1]    = ms_pick(ms_sel_i, xt_fault, xt_hf_i);
    want[2]    = want[1];
    div_sel[0] = '0;
    div_sel[1] = DIV_W_MAX'(main_div_i);
    div_sel[2] = DIV_W_MAX'(sub_div_i);
    run[0]     = 1'b1;
    run[1]     = 1'b1;
    run[2]     = !sub_off_i;
  end

  for (genvar g = 0; g < N_DEST; g++) begin : g_dest
    clksel_switch #(.RST_SRC(SRC_REF)) u_sw (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_i (want[g]),
      .ticks_i(ticks),
      .div_i  (div_sel[g]),
      .run_i  (run[g]),
      .tick_o (dtick[g])
    );
  end

  assign aux_tick_o  = dtick[0];
  assign main_tick_o = dtick[1];
  assign sub_tick_o  = dtick[2];

  // Sticky flags: setting wins over a clear strobe in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xt_flag_q  <= 1'b0;
      osc_flag_q <= 1'b0;
      glob_q     <= 1'b0;
    end else begin
      xt_flag_q  <= xt_fault || (xt_flag_q && !clr_xt_flag_i);
      osc_flag_q <= osc_fault_i || (osc_flag_q && !clr_osc_flag_i);
      glob_q     <= xt_flag_q || osc_flag_q || (glob_q && !clr_glob_flag_i);
    end
  end

  assign xt_fault_flag_o   = xt_flag_q;
  assign osc_fault_flag_o  = osc_flag_q;
  assign glob_fault_flag_o = glob_q;

  AST_XT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    xt_fault |=> xt_flag_q); // R7
  AST_XT_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_flag_q && !clr_xt_flag_i) |=> xt_flag_q); // R7
  AST_OSC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fault_i |=> osc_flag_q); // R8
  AST_GLOB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_flag_q || osc_flag_q) |=> glob_q); // R9
  AST_SUB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sub_off_i |-> !sub_tick_o); // R10
endmodule

// File: tb/tb_clksel_failsafe.sv
`timescale 1ns/1ps
module tb_clksel_failsafe;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic xt_tick, ref_tick, vlo_tick, osc_tick, osc_fault, xt_hf, xt_autooff;
  logic [1:0] aux_sel, ms_sel, sub_div;
  logic [2:0] main_div;
  logic sub_off, clr_xt, clr_osc, clr_glob;
  logic aux_o, main_o, sub_o, xtf_o, oscf_o, glob_o;

  // stimulus shadows, applied at a falling edge by cyc()
  int s_rst = 0, s_alive = 1, s_oscf = 0, s_hf = 0, s_ao = 0;
  int s_aux = 0, s_ms = 3, s_mdiv = 0, s_sdiv = 0, s_off = 0;
  int s_cx = 0, s_co = 0, s_cg = 0;

  int checks = 0, failures = 0, n = 0, sub_seen = 0;

  // behavioural model state
  int wd = 0, m_xt = 0, m_osc = 0, m_glob = 0;
  int m_cur[3] = '{1, 1, 1};
  int m_gap[3] = '{0, 0, 0};
  int m_cnt[3] = '{0, 0, 0};

  clksel_failsafe dut (
    .clk(clk), .rst_n(rst_n), .xt_tick_i(xt_tick), .ref_tick_i(ref_tick),
    .vlo_tick_i(vlo_tick), .osc_tick_i(osc_tick), .osc_fault_i(osc_fault),
    .xt_hf_i(xt_hf), .xt_autooff_i(xt_autooff), .aux_sel_i(aux_sel),
    .ms_sel_i(ms_sel), .main_div_i(main_div), .sub_div_i(sub_div),
    .sub_off_i(sub_off), .clr_xt_flag_i(clr_xt), .clr_osc_flag_i(clr_osc),
    .clr_glob_flag_i(clr_glob), .aux_tick_o(aux_o), .main_tick_o(main_o),
    .sub_tick_o(sub_o), .xt_fault_flag_o(xtf_o), .osc_fault_flag_o(oscf_o),
    .glob_fault_flag_o(glob_o)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, n);
    end
  endtask

  function automatic int tick_of(input int src);
    if (src == 0) return int'(xt_tick);
    if (src == 1) return int'(ref_tick);
    if (src == 2) return int'(vlo_tick);
    return int'(osc_tick);
  endfunction

  task automatic cyc();
    int on, flt, w[3], dv[3], rn[3], ex[3];
    @(negedge clk);
    n++;
    rst_n = (s_rst != 0); osc_fault = (s_oscf != 0); xt_hf = (s_hf != 0);
    xt_autooff = (s_ao != 0); aux_sel = 2'(s_aux); ms_sel = 2'(s_ms);
    main_div = 3'(s_mdiv); sub_div = 2'(s_sdiv); sub_off = (s_off != 0);
    clr_xt = (s_cx != 0); clr_osc = (s_co != 0); clr_glob = (s_cg != 0);
    xt_tick  = (s_alive != 0) && (n % 4 == 0);
    ref_tick = (n % 8 == 3);
    vlo_tick = (n % 25 == 7);
    osc_tick = (n % 2 == 1);
    #1;
    on  = (s_ao == 0 || s_aux == 0 || s_ms == 0) ? 1 : 0;
    flt = (on == 1 && wd >= 64) ? 1 : 0;
    // wanted sources
    if (s_aux == 1) w[0] = 1;
    else if (s_aux >= 2) w[0] = 2;
    else w[0] = flt ? 1 : 0;
    if (s_ms != 0) w[1] = s_ms;
    else if (!flt) w[1] = 0;
    else w[1] = s_hf ? 3 : 1;
    w[2] = w[1];
    dv[0] = 1; dv[1] = 1 << s_mdiv; dv[2] = 1 << s_sdiv;
    rn[0] = 1; rn[1] = 1; rn[2] = s_off ? 0 : 1;
    for (int g = 0; g < 3; g++)
      ex[g] = (rn[g] && !m_gap[g] && tick_of(m_cur[g]) && m_cnt[g] >= dv[g] - 1) ? 1 : 0;
    if (s_rst != 0) begin
      chk(int'(aux_o), ex[0], "R1 R5 aux edge");
      chk(int'(main_o), ex[1], "R2 R3 R6 R12 main edge");
      chk(int'(sub_o), ex[2], "R3 R10 R12 sub edge");
      chk(int'(xtf_o), m_xt, "R4 R7 crystal flag");
      chk(int'(oscf_o), m_osc, "R8 oscillator flag");
      chk(int'(glob_o), m_glob, "R9 global flag");
    end
    if (sub_o) sub_seen++;
    // advance the model by one clock
    if (s_rst == 0) begin
      wd = 0; m_xt = 0; m_osc = 0; m_glob = 0;
      for (int g = 0; g < 3; g++) begin m_cur[g] = 1; m_gap[g] = 0; m_cnt[g] = 0; end
    end else begin
      m_glob = (m_xt || m_osc || (m_glob && !s_cg)) ? 1 : 0;
      m_xt   = (flt || (m_xt && !s_cx)) ? 1 : 0;
      m_osc  = (s_oscf || (m_osc && !s_co)) ? 1 : 0;
      if (!on || xt_tick) wd = 0;
      else if (ref_tick && wd < 64) wd++;
      for (int g = 0; g < 3; g++) begin
        if (m_gap[g]) begin m_cur[g] = w[g]; m_gap[g] = 0; m_cnt[g] = 0; end
        else if (w[g] != m_cur[g]) m_gap[g] = 1;
        else if (rn[g] && tick_of(m_cur[g]))
          m_cnt[g] = (m_cnt[g] >= dv[g] - 1) ? 0 : m_cnt[g] + 1;
      end
    end
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  initial begin
    #(4.0 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    s_rst = 0; run(4);
    s_rst = 1; run(1);
    chk(int'(xtf_o), 0, "R7 reset crystal flag");
    chk(int'(oscf_o), 0, "R8 reset oscillator flag");
    chk(int'(glob_o), 0, "R9 reset global flag");
    // plain selection and division
    s_aux = 0; s_ms = 3; s_mdiv = 2; s_sdiv = 1; run(300);
    s_ms = 0; s_mdiv = 7; s_sdiv = 3; run(600);
    s_ms = 1; s_mdiv = 1; run(200);
    s_ms = 2; s_mdiv = 0; s_sdiv = 0; s_aux = 2; run(300);
    s_aux = 1; run(100);
    s_aux = 3; run(100);
    // select steps on consecutive cycles (R12)
    s_ms = 1; cyc(); s_ms = 2; cyc(); s_ms = 3; run(100);
    // crystal stops in low-frequency mode
    s_aux = 0; s_ms = 0; s_mdiv = 1; s_hf = 0; s_alive = 0; run(600);
    chk(int'(xtf_o), 1, "R4 crystal flag after 64 reference edges");
    chk(int'(glob_o), 1, "R9 global flag follows crystal flag");
    s_cx = 1; s_cg = 1; cyc(); s_cx = 0; s_cg = 0; cyc();
    chk(int'(xtf_o), 1, "R7 clear loses to a present fault");
    chk(int'(glob_o), 1, "R9 clear loses to a set crystal flag");
    // high-frequency fallback
    s_hf = 1; run(200);
    s_ms = 1; cyc(); s_ms = 0; run(100);
    // crystal returns
    s_alive = 1; run(30);
    s_cx = 1; cyc(); s_cx = 0; cyc();
    chk(int'(xtf_o), 0, "R7 clear after fault ends");
    s_cg = 1; cyc(); s_cg = 0; cyc();
    chk(int'(glob_o), 0, "R9 clear once no flag is set");
    // sub-main off
    s_sdiv = 1; sub_seen = 0; s_off = 1; run(100);
    chk(sub_seen, 0, "R10 no sub-main edges while off");
    s_off = 0; run(100);
    // oscillator fault
    s_oscf = 1; cyc(); s_oscf = 0; cyc();
    chk(int'(oscf_o), 1, "R8 oscillator flag set");
    cyc();
    chk(int'(glob_o), 1, "R9 global flag follows oscillator flag");
    s_co = 1; cyc(); s_co = 0; cyc();
    chk(int'(oscf_o), 0, "R8 oscillator flag cleared");
    s_cg = 1; cyc(); s_cg = 0; cyc();
    // auto-off with nobody on the crystal
    s_ao = 1; s_aux = 1; s_ms = 3; s_alive = 0; run(700);
    chk(int'(xtf_o), 0, "R11 no fault while crystal disabled");
    s_ms = 0; s_hf = 0; run(600);
    chk(int'(xtf_o), 1, "R4 R11 watchdog runs once crystal selected");
    s_alive = 1; run(100);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule